// File: doc/BRIEF.md
# Redundant Joint-State Selector with Capacitor Balancing

This block serves a pair of cascaded three-level inverters that together act as an eleven-level converter. The modulator produces a joint three-phase level vector, with each phase in the range 0 to 10. The top inverter contributes four level steps per state and the bottom inverter contributes one, so equivalent levels 3 and 7 cannot be built. The block searches every common-mode shift of the incoming vector. A common-mode shift adds the same integer to all three phases, which changes only the zero-sequence voltage. The block keeps the shifted vectors that stay inside 0..10 and avoid the unbuildable levels. From these it chooses the one that best steers both dc-link midpoints back toward balance.

The balancing score uses three inputs: a current-direction flag per phase and one capacitor-imbalance flag per inverter. The result is registered and delivered on a valid/ready stream. It carries the chosen levels, their split into top and bottom inverter states, and a flag for vectors that have no legal equivalent. The input is also a valid/ready stream. There is one result register: a new vector is accepted whenever that register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result is held and `in_ready` is low.

Top module: `redundancy_balancer`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. A vector accepted on a rising edge appears with `out_valid` high after that edge. A result is consumed on an edge where `out_valid && out_ready`.
- R2: While `out_valid` is high and `out_ready` is low, every output stays unchanged.
- R3: When a remedy exists, the output levels equal the input levels plus one common signed shift k. Every output level lies in 0..10.
- R4: A remedy exists when at least one shift gives levels that are all in 0..10 and none equal to 3 or 7. In that case `out_none` is 0 and no output level is 3 or 7. For example, (1,3,9) maps to either (0,2,8) or (2,4,10).
- R5: When no shift qualifies, `out_none` is 1, the output levels equal the input, and `out_top` and `out_bot` are all zero. An example is (0,3,10).
- R6: Each output level L satisfies L = 4*T + B, with top state T and bottom state B each in 0..2. In `out_top` and `out_bot`, phase a sits at bits [1:0], phase b at [3:2] and phase c at [5:4].
- R7: Score. For each phase, an inverter whose state is 1 contributes +1 if that phase's direction flag (`in_idir` bit 0 = a, 1 = b, 2 = c) is 1, and -1 otherwise. A state of 0 or 2 contributes nothing. Each inverter's sum is negated when its imbalance flag is 0. The score is the top result plus the bottom result.
- R8: Among the qualifying shifts, the one with the highest score is chosen.
- R9: Equal scores are resolved first by the smaller |k|, and then by the negative k.
- R10: While `rst_n` is low, `out_valid` is 0. Input levels must be 0..10 while `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input vector valid |
| in_ready | output | 1 | Input vector accepted when high with in_valid |
| in_lvl_a | input | 4 | Phase a equivalent level 0..10 |
| in_lvl_b | input | 4 | Phase b equivalent level 0..10 |
| in_lvl_c | input | 4 | Phase c equivalent level 0..10 |
| in_idir | input | 3 | Current direction flags, bit 0 = phase a |
| in_cap_top | input | 1 | Top inverter imbalance flag |
| in_cap_bot | input | 1 | Bottom inverter imbalance flag |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts result |
| out_lvl_a | output | 4 | Chosen phase a level |
| out_lvl_b | output | 4 | Chosen phase b level |
| out_lvl_c | output | 4 | Chosen phase c level |
| out_top | output | 6 | Top inverter states, 2 bits per phase |
| out_bot | output | 6 | Bottom inverter states, 2 bits per phase |
| out_none | output | 1 | No legal equivalent vector exists |

## Verification
Two things can fall in the same cycle: draining the held result and accepting the next vector. The bench provokes this by streaming two vectors back to back with `out_ready` held high. It expects the second result to replace the first exactly one edge later, with the first never repeated. In the other transactions it holds `out_ready` low for random stretches and requires both the stored result and a low `in_ready` to persist. Every result is compared with a bench model that scans shifts in order of preference.

// File: rtl/rsel_pkg.sv
package rsel_pkg;
  localparam int PHASES     = 3;
  localparam int INV_LEVELS = 3;
  localparam int RADIX      = INV_LEVELS + 1;
  localparam int MAX_LVL    = RADIX * (INV_LEVELS - 1) + INV_LEVELS - 1;
  localparam int LVL_W      = $clog2(MAX_LVL + 1);
  localparam int ST_W       = $clog2(INV_LEVELS);
  localparam int MID_ST     = (INV_LEVELS - 1) / 2;
  localparam int NCAND      = 2 * MAX_LVL + 1;
  localparam int IDX_W      = $clog2(NCAND);
  localparam int SC_W       = $clog2(2 * PHASES + 1) + 2;

  typedef logic [LVL_W-1:0] lvl_t;

  // shift tried at preference position p: 0, -1, +1, -2, +2, ...
  function automatic int pref_shift(input int p);
    if (p == 0) return 0;
    if (p % 2 == 1) return -((p + 1) / 2);
    return p / 2;
  endfunction

  function automatic logic lvl_legal(input lvl_t l);
    return (int'(l) <= MAX_LVL) && ((int'(l) % RADIX) < INV_LEVELS);
  endfunction
endpackage

// File: rtl/rsel_cand.sv
module rsel_cand
  import rsel_pkg::*;
#(
  parameter int SHIFT = 0
) (
  input  logic [PHASES-1:0][LVL_W-1:0] lvl,
  input  logic [PHASES-1:0]            idir,
  input  logic                         cap_top,
  input  logic                         cap_bot,
  output logic                         ok,
  output logic signed [SC_W-1:0]       score,
  output logic [PHASES-1:0][LVL_W-1:0] shifted
);
  int v, ctop, cbot, total;

  always_comb begin
    ok   = 1'b1;
    ctop = 0;
    cbot = 0;
    v    = 0;
    for (int ph = 0; ph < PHASES; ph++) begin
      v = int'(lvl[ph]) + SHIFT;
      shifted[ph] = LVL_W'(v);
      if (v < 0 || v > MAX_LVL) ok = 1'b0;
      else if ((v % RADIX) >= INV_LEVELS) ok = 1'b0;
      if (v >= 0 && (v / RADIX) == MID_ST) ctop = ctop + (idir[ph] ? 1 : -1);
      if (v >= 0 && (v % RADIX) == MID_ST) cbot = cbot + (idir[ph] ? 1 : -1);
    end
    total = (cap_top ? ctop : -ctop) + (cap_bot ? cbot : -cbot);
    score = SC_W'(total);
  end
endmodule

// File: rtl/rsel_pick.sv
module rsel_pick
  import rsel_pkg::*;
(
  input  logic [NCAND-1:0]           ok,
  input  logic [NCAND-1:0][SC_W-1:0] score,
  output logic                       found,
  output logic [IDX_W-1:0]           idx
);
  logic signed [SC_W-1:0] best;

  // candidates arrive in preference order, so only a strictly higher score displaces
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int p = 0; p < NCAND; p++) begin
      if (ok[p] && (!found || $signed(score[p]) > best)) begin
        found = 1'b1;
        idx   = IDX_W'(p);
        best  = $signed(score[p]);
      end
    end
  end
endmodule

// File: rtl/rsel_split.sv
module rsel_split
  import rsel_pkg::*;
(
  input  logic [LVL_W-1:0] lvl,
  output logic [ST_W-1:0]  top_st,
  output logic [ST_W-1:0]  bot_st
);
  always_comb begin
    top_st = ST_W'(int'(lvl) / RADIX);
    bot_st = ST_W'(int'(lvl) % RADIX);
  end
endmodule

// File: rtl/redundancy_balancer.sv
module redundancy_balancer
  import rsel_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LVL_W-1:0]        in_lvl_a,
  input  logic [LVL_W-1:0]        in_lvl_b,
  input  logic [LVL_W-1:0]        in_lvl_c,
  input  logic [PHASES-1:0]       in_idir,
  input  logic                    in_cap_top,
  input  logic                    in_cap_bot,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LVL_W-1:0]        out_lvl_a,
  output logic [LVL_W-1:0]        out_lvl_b,
  output logic [LVL_W-1:0]        out_lvl_c,
  output logic [PHASES*ST_W-1:0]  out_top,
  output logic [PHASES*ST_W-1:0]  out_bot,
  output logic                    out_none
);
  logic [PHASES-1:0][LVL_W-1:0]            lvl_in, lvl_sel;
  logic [NCAND-1:0]                        cand_ok;
  logic [NCAND-1:0][SC_W-1:0]              cand_sc;
  logic [NCAND-1:0][PHASES-1:0][LVL_W-1:0] cand_lvl;
  logic                                    found;
  logic [IDX_W-1:0]                        win;
  logic [PHASES*ST_W-1:0]                  top_sel, bot_sel;
  logic                                    accept;

  assign lvl_in   = {in_lvl_c, in_lvl_b, in_lvl_a};
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  for (genvar p = 0; p < NCAND; p++) begin : g_cand
    rsel_cand #(.SHIFT(pref_shift(p))) u_cand (
      .lvl(lvl_in), .idir(in_idir), .cap_top(in_cap_top), .cap_bot(in_cap_bot),
      .ok(cand_ok[p]), .score(cand_sc[p]), .shifted(cand_lvl[p])
    );
  end

  rsel_pick u_pick (.ok(cand_ok), .score(cand_sc), .found(found), .idx(win));

  assign lvl_sel = found ? cand_lvl[win] : lvl_in;

  for (genvar ph = 0; ph < PHASES; ph++) begin : g_split
    rsel_split u_split (
      .lvl(lvl_sel[ph]),
      .top_st(top_sel[ph*ST_W +: ST_W]),
      .bot_st(bot_sel[ph*ST_W +: ST_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_lvl_a <= '0;
      out_lvl_b <= '0;
      out_lvl_c <= '0;
      out_top   <= '0;
      out_bot   <= '0;
      out_none  <= 1'b0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_lvl_a <= lvl_sel[0];
        out_lvl_b <= lvl_sel[1];
        out_lvl_c <= lvl_sel[2];
        out_top   <= found ? top_sel : '0;
        out_bot   <= found ? bot_sel : '0;
        out_none  <= !found;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R1
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_lvl_a) && $stable(out_lvl_b)
      && $stable(out_lvl_c) && $stable(out_top) && $stable(out_bot) && $stable(out_none));

  // R3
  spread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_none
      || ((LVL_W'(out_lvl_a - out_lvl_b) == $past(LVL_W'(in_lvl_a - in_lvl_b)))
      &&  (LVL_W'(out_lvl_a - out_lvl_c) == $past(LVL_W'(in_lvl_a - in_lvl_c)))));

  // R4
  no_forbidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_none |-> lvl_legal(out_lvl_a) && lvl_legal(out_lvl_b) && lvl_legal(out_lvl_c));

  // R5
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !out_none
      || (out_lvl_a == $past(in_lvl_a) && out_lvl_b == $past(in_lvl_b)
      && out_lvl_c == $past(in_lvl_c) && out_top == '0 && out_bot == '0));

  // R6
  split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_none |->
      int'(out_lvl_a) == RADIX * int'(out_top[ST_W-1:0]) + int'(out_bot[ST_W-1:0]));

  // R10
  in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> int'(in_lvl_a) <= MAX_LVL && int'(in_lvl_b) <= MAX_LVL && int'(in_lvl_c) <= MAX_LVL);
endmodule

// File: tb/redundancy_balancer_test.sv
module redundancy_balancer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, out_none;
  logic [3:0] in_lvl_a = '0, in_lvl_b = '0, in_lvl_c = '0;
  logic [2:0] in_idir = '0;
  logic in_cap_top = 1'b0, in_cap_bot = 1'b0;
  logic [3:0] out_lvl_a, out_lvl_b, out_lvl_c;
  logic [5:0] out_top, out_bot;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  redundancy_balancer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_lvl_a(in_lvl_a), .in_lvl_b(in_lvl_b), .in_lvl_c(in_lvl_c),
    .in_idir(in_idir), .in_cap_top(in_cap_top), .in_cap_bot(in_cap_bot),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_lvl_a(out_lvl_a), .out_lvl_b(out_lvl_b), .out_lvl_c(out_lvl_c),
    .out_top(out_top), .out_bot(out_bot), .out_none(out_none)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected result from the requirements: scan shifts 0,-1,+1,-2,+2,... keep strictly better
  function automatic void model(input int a, input int b, input int c, input logic [2:0] d,
                                input logic ft, input logic fb,
                                output int ea, output int eb, output int ec, output bit none);
    int lv[3];
    int best, k, ct, cb, sc;
    bit ok;
    none = 1; best = 0; ea = a; eb = b; ec = c;
    for (int p = 0; p < 21; p++) begin
      k = (p == 0) ? 0 : ((p % 2 == 1) ? -((p + 1) / 2) : p / 2);
      lv[0] = a + k; lv[1] = b + k; lv[2] = c + k;
      ok = 1; ct = 0; cb = 0;
      for (int i = 0; i < 3; i++) begin
        if (lv[i] < 0 || lv[i] > 10 || lv[i] == 3 || lv[i] == 7) ok = 0;
        else begin
          if (lv[i] / 4 == 1) ct += d[i] ? 1 : -1;
          if (lv[i] % 4 == 1) cb += d[i] ? 1 : -1;
        end
      end
      sc = (ft ? ct : -ct) + (fb ? cb : -cb);
      if (ok && (none || sc > best)) begin
        none = 0; best = sc; ea = lv[0]; eb = lv[1]; ec = lv[2];
      end
    end
  endfunction

  function automatic logic [5:0] pack_st(input int a, input int b, input int c, input bit hi);
    return hi ? {2'(c / 4), 2'(b / 4), 2'(a / 4)} : {2'(c % 4), 2'(b % 4), 2'(a % 4)};
  endfunction

  task automatic check_out(input string req, input int ea, input int eb, input int ec, input bit en);
    chk(out_valid == 1'b1, "R1", int'(out_valid), 1);
    chk(out_none == en, en ? "R5" : "R4", int'(out_none), int'(en));
    chk(out_lvl_a == 4'(ea) && out_lvl_b == 4'(eb) && out_lvl_c == 4'(ec), req,
        int'({out_lvl_a, out_lvl_b, out_lvl_c}), int'({4'(ea), 4'(eb), 4'(ec)}));
    if (en)
      chk(out_top == 6'd0 && out_bot == 6'd0, "R5", int'({out_top, out_bot}), 0);
    else
      chk(out_top == pack_st(ea, eb, ec, 1) && out_bot == pack_st(ea, eb, ec, 0), "R6",
          int'({out_top, out_bot}), int'({pack_st(ea, eb, ec, 1), pack_st(ea, eb, ec, 0)}));
  endtask

  task automatic run(input int a, input int b, input int c, input logic [2:0] d,
                     input logic ft, input logic fb, input int stall, input string req);
    int ea, eb, ec;
    bit en;
    model(a, b, c, d, ft, fb, ea, eb, ec, en);
    @(negedge clk);
    in_lvl_a = 4'(a); in_lvl_b = 4'(b); in_lvl_c = 4'(c);
    in_idir = d; in_cap_top = ft; in_cap_bot = fb;
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check_out(req, ea, eb, ec, en);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R1", int'(in_ready), 0);
      check_out("R2", ea, eb, ec, en);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
  endtask

  initial begin
    int a, b, c, ea, eb, ec;
    bit en;
    void'($urandom(32'd20240611));
    #23;
    chk(out_valid == 1'b0, "R10", int'(out_valid), 0);
    rst_n = 1'b1;
    // R7: (1,3,9) score of +1 shift is +1 with phase b current positive and top flag set
    run(1, 3, 9, 3'b010, 1'b1, 1'b0, 2, "R7");
    // R7: same vector, top flag cleared: +1 shift scores -1, so the -1 shift wins
    run(1, 3, 9, 3'b010, 1'b0, 1'b0, 0, "R7");
    // R5: spread of 10 with level 3 has no remedy
    run(0, 3, 10, 3'b101, 1'b1, 1'b1, 1, "R5");
    // R9: (5,5,5) shifts -1 and +1 tie at the best score, negative wins
    run(5, 5, 5, 3'b000, 1'b0, 1'b1, 0, "R9");
    // R9: all-zero vector, zero shift ties with larger shifts and wins
    run(0, 0, 0, 3'b111, 1'b0, 1'b0, 0, "R9");
    // R3: legal vector with spread 10 has one candidate
    run(10, 0, 4, 3'b011, 1'b1, 1'b0, 0, "R3");
    // back-to-back: drain and accept in the same edge
    @(negedge clk);
    in_lvl_a = 4'd2; in_lvl_b = 4'd6; in_lvl_c = 4'd9; in_idir = 3'b110;
    in_cap_top = 1'b1; in_cap_bot = 1'b1; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    model(2, 6, 9, 3'b110, 1'b1, 1'b1, ea, eb, ec, en);
    check_out("R8", ea, eb, ec, en);
    chk(in_ready == 1'b1, "R1", int'(in_ready), 1);
    in_lvl_a = 4'd7; in_lvl_b = 4'd3; in_lvl_c = 4'd5; in_idir = 3'b001; in_cap_bot = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    model(7, 3, 5, 3'b001, 1'b1, 1'b0, ea, eb, ec, en);
    check_out("R1", ea, eb, ec, en);
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
    // R8: constrained random vectors and flags
    for (int n = 0; n < 400; n++) begin
      a = int'($urandom_range(0, 10));
      b = int'($urandom_range(0, 10));
      c = int'($urandom_range(0, 10));
      run(a, b, c, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
          1'($urandom_range(0, 1)), int'($urandom_range(0, 3)), "R8");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule